// File: doc/BRIEF.md
# Serial-Fed Transmit Byte Buffer with Low-Water Ready Flag

This block accepts payload bytes from a host over a write-only serial peripheral link (SPI mode 0) and queues them in a byte FIFO. The FIFO drains toward the channel encoder through a valid/ready byte port. A transmit-ready output tells the host to send more data. It asserts when the stored byte count falls below a low-water threshold, well before the buffer empties, so an interrupt-driven host still has a large reserve to refill. The same flag is also presented as a status bit for telemetry, next to the fill level and a sticky overflow indicator.

Bytes are assembled in the serial-clock domain. Each finished byte is handed to the system clock domain through a toggle that is passed through two synchroniser flops. In synchronisation mode the encoder is sending preamble words, so the FIFO is not drained. The host may keep writing until the buffer is full, and in this mode the ready flag means only "not full".

Back-pressure on the read port: `out_valid` is high whenever the FIFO holds data and synchronisation mode is off. A byte leaves the FIFO only on a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

Top module: `tx_byte_buffer`

## Requirements
- R1: Serial bytes are taken MSB first, with MOSI sampled on rising SCK while CS (active low) is low. The eighth rising edge completes a byte, and that byte is written into the FIFO.
- R2: If CS rises before the eighth edge, the partial byte is discarded. The next byte starts again from its first bit.
- R3: A byte that arrives while the FIFO holds DEPTH bytes is dropped, the fill count stays at DEPTH, and the overflow bit sets and remains set until reset.
- R4: Outside synchronisation mode, `tx_ready` is high exactly when the registered fill count is below THRESH. It follows a change of the count one system clock later.
- R5: `stat_tx_ready` always equals `tx_ready`.
- R6: In synchronisation mode `out_valid` stays low and nothing is drained. Writes are still accepted up to full, and `tx_ready` is high exactly when the FIFO is not full.
- R7: Bytes leave in arrival order, one per cycle with both `out_valid` and `out_ready` high. `out_data` stays stable while `out_valid` is high and `out_ready` is low.
- R8: After reset the fill count is 0, `tx_ready` is 1, `out_valid` is 0 and the overflow bit is 0.
- R9: `stat_fill` gives the number of bytes stored. It rises by one per accepted byte and falls by one per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Serial select, active low |
| sync_mode | input | 1 | Synchronisation mode: hold the FIFO, ready means not full |
| out_data | output | 8 | Byte at the FIFO head |
| out_valid | output | 1 | Head byte available |
| out_ready | input | 1 | Encoder accepts the head byte |
| tx_ready | output | 1 | Host may send more data |
| stat_tx_ready | output | 1 | Telemetry copy of tx_ready |
| stat_fill | output | $clog2(DEPTH+1) | Stored byte count |
| stat_overflow | output | 1 | Sticky: a byte was dropped at full |

## Verification
The bench builds the buffer with DEPTH=16 and THRESH=5, instead of 4096 and 513. With these values, both the low-water crossing and completely filling the FIFO take only a few dozen serial bytes. That brings into reach the one-cycle lag of the ready flag as the count crosses the threshold, the switch to the full-based ready in synchronisation mode, and the drop-at-full overflow path. The same logic runs at the default size, because the threshold compare and the pointer wrap are written in terms of the parameters.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
  import txbuf_pkg::*;
(
  input  logic  rst_n,
  input  logic  sck,
  input  logic  mosi,
  input  logic  cs_n,
  output byte_t byte_q,
  output logic  byte_tog
);
  logic [2:0]        bit_cnt;
  logic [BYTE_W-2:0] shift_q;

  // Bit position and partial data; CS high clears them asynchronously (R2)
  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
    end else begin
      bit_cnt <= bit_cnt + 3'd1;
      shift_q <= {shift_q[BYTE_W-3:0], mosi};
    end
  end

  // Completed byte and handoff toggle; they must not clear on CS (R1)
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      byte_q   <= '0;
      byte_tog <= 1'b0;
    end else if (!cs_n && bit_cnt == 3'd7) begin
      byte_q   <= {shift_q, mosi};
      byte_tog <= ~byte_tog;
    end
  end
endmodule

// File: rtl/byte_cdc.sv
module byte_cdc
  import txbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t src_byte,
  input  logic  src_tog,
  output logic  wr_en,
  output byte_t wr_data
);
  logic [2:0] tog_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_sync <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      tog_sync <= {tog_sync[1:0], src_tog};
      wr_en    <= tog_sync[2] ^ tog_sync[1];
      // The source byte has been stable for at least two cycles here
      if (tog_sync[2] ^ tog_sync[1]) wr_data <= src_byte;
    end
  end

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  byte_t         wr_data,
  input  logic          rd_en,
  output byte_t         rd_data,
  output logic [CW-1:0] count,
  output logic          overflow
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_wr, do_rd;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      if (do_wr && !do_rd)      count <= count + CW'(1);
      else if (do_rd && !do_wr) count <= count - CW'(1);
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_at_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (count == CW'(DEPTH)) && overflow);
  assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_fill_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> $stable(count));
endmodule

// File: rtl/tx_byte_buffer.sv
module tx_byte_buffer
  import txbuf_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int THRESH = 513,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_cs_n,
  input  logic          sync_mode,
  output logic [7:0]    out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          tx_ready,
  output logic          stat_tx_ready,
  output logic [CW-1:0] stat_fill,
  output logic          stat_overflow
);
  byte_t spi_byte, wr_data;
  logic  spi_tog, wr_en, ready_q;

  spi_byte_rx u_rx (
    .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .byte_q(spi_byte), .byte_tog(spi_tog)
  );

  byte_cdc u_cdc (
    .clk(clk), .rst_n(rst_n), .src_byte(spi_byte), .src_tog(spi_tog),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(out_valid && out_ready), .rd_data(out_data),
    .count(stat_fill), .overflow(stat_overflow)
  );

  assign out_valid = (stat_fill != '0) && !sync_mode;

  // Ready is computed from the registered count, so it lags the count by one clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b1;
    else if (sync_mode) ready_q <= (stat_fill != CW'(DEPTH));
    else ready_q <= (stat_fill < CW'(THRESH));
  end

  assign tx_ready      = ready_q;
  assign stat_tx_ready = ready_q;

  assert_ready_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_mode) |=> tx_ready == ($past(stat_fill) < CW'(THRESH)));
  assert_sync_no_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> stat_fill >= $past(stat_fill));
  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: tb/sim_tx_byte_buffer.sv
`timescale 1ns/1ps
module sim_tx_byte_buffer;
  localparam int DEPTH = 16;
  localparam int THRESH = 5;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'h5A, 8'hC3, 8'h01, 8'h80};

  logic clk = 0, rst_n = 0, sck = 0, mosi = 0, cs_n = 1, sync_mode = 0, out_ready = 0;
  logic [7:0] out_data;
  logic out_valid, tx_ready, stat_tx_ready, stat_overflow;
  logic [CW-1:0] stat_fill;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tx_byte_buffer #(.DEPTH(DEPTH), .THRESH(THRESH)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .sync_mode(sync_mode), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .tx_ready(tx_ready), .stat_tx_ready(stat_tx_ready),
    .stat_fill(stat_fill), .stat_overflow(stat_overflow));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nbits);
    cs_n = 0; #20;
    for (int k = 0; k < nbits; k++) begin
      mosi = b[7-k]; #20 sck = 1; #20 sck = 0;
    end
    #20 cs_n = 1; #40;
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pop_one();
    out_ready = 1; @(posedge clk); @(negedge clk); out_ready = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(stat_fill == 0, "R8 fill", stat_fill, 0);
    check(tx_ready == 1, "R8 ready", tx_ready, 1);
    check(out_valid == 0, "R8 valid", out_valid, 0);
    check(stat_overflow == 0, "R8 ovf", stat_overflow, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Table loop: R1 bytes written, R9 count, R4 threshold, R5 mirror
    for (int i = 0; i < NV; i++) begin
      spi_bits(VEC[i], 8);
      check(stat_fill == CW'(i + 1), "R9 fill after write", stat_fill, i + 1);
      check(tx_ready == ((i + 1) < THRESH), "R4 ready vs threshold", tx_ready, (i + 1) < THRESH);
      check(stat_tx_ready == tx_ready, "R5 mirror", stat_tx_ready, tx_ready);
    end

    // R7 hold under back-pressure
    check(out_valid == 1, "R7 valid", out_valid, 1);
    check(out_data == VEC[0], "R7 head", out_data, VEC[0]);
    repeat (5) @(negedge clk);
    check(out_data == VEC[0] && stat_fill == CW'(NV), "R7 hold", out_data, VEC[0]);

    // R1/R7 order on drain; R4 lag when crossing below THRESH
    for (int i = 0; i < NV; i++) begin
      check(out_data == VEC[i], "R1 data order", out_data, VEC[i]);
      pop_one();
      if (NV - 1 - i == THRESH - 1) begin
        check(tx_ready == 0, "R4 ready lags count", tx_ready, 0);
        @(negedge clk);
        check(tx_ready == 1, "R4 ready after lag", tx_ready, 1);
      end
    end
    check(stat_fill == 0 && out_valid == 0, "R9 empty after drain", stat_fill, 0);

    // R2 partial byte discarded
    spi_bits(8'hFF, 5);
    check(stat_fill == 0, "R2 partial not stored", stat_fill, 0);
    spi_bits(8'hA5, 8);
    check(stat_fill == 1 && out_data == 8'hA5, "R2 clean restart", out_data, 8'hA5);
    pop_one();

    // R6 sync mode: no drain, ready = not full; R3 overflow
    sync_mode = 1; out_ready = 1;
    @(negedge clk);
    check(out_valid == 0, "R6 valid low", out_valid, 0);
    for (int i = 0; i < DEPTH - 1; i++) spi_bits(8'(i + 16), 8);
    check(stat_fill == CW'(DEPTH - 1), "R6 no drain", stat_fill, DEPTH - 1);
    check(tx_ready == 1, "R6 ready above threshold", tx_ready, 1);
    spi_bits(8'h77, 8);
    check(tx_ready == 0, "R6 ready low at full", tx_ready, 0);
    check(stat_overflow == 0, "R3 no ovf yet", stat_overflow, 0);
    spi_bits(8'h99, 8);
    spi_bits(8'h98, 8);
    check(stat_fill == CW'(DEPTH), "R3 fill capped", stat_fill, DEPTH);
    check(stat_overflow == 1, "R3 ovf set", stat_overflow, 1);

    // Leave sync: drain resumes, dropped bytes absent, overflow sticky
    out_ready = 0; sync_mode = 0;
    @(negedge clk);
    check(out_valid == 1 && out_data == 8'd16, "R7 head after sync", out_data, 16);
    for (int i = 0; i < DEPTH; i++) pop_one();
    check(stat_fill == 0, "R9 drained", stat_fill, 0);
    check(stat_overflow == 1, "R3 ovf sticky", stat_overflow, 1);
    @(negedge clk);
    check(tx_ready == 1 && stat_tx_ready == 1, "R5 ready at empty", tx_ready, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule